// File: doc/BRIEF.md
# Vectored interrupt acceptance controller

This block collects interrupt requests from eighteen maskable sources, numbered 4 to 21, and from one non-maskable source, numbered 2. Each request sets a latch. A latch stays set until its source is accepted or software clears it. A maskable latch can be accepted only when its own enable flag is set and the global master enable is set. The non-maskable latch ignores both. When several requests are eligible, the lowest source number wins, and the non-maskable source wins over all of them.

The CPU pulses `insn_end` at every instruction boundary. If an eligible request is pending while the controller is idle, the controller runs a fixed eight-cycle acceptance sequence:

- It clears the master enable.
- It clears the winner's latch.
- It pushes three bytes downward on the stack: the status byte, which carries the master enable as it was before acceptance, then the PC high byte, then the PC low byte.
- It gives the CPU a stack pointer three lower than before.
- It presents the 16-bit vector-fetch address for the winner.

The CPU, the memory and the vector table sit outside the block. On either return instruction the CPU hands back the saved master enable bit, and the block restores the master enable from it.

The stack writes, the stack pointer load and the vector address are one-cycle strobes with no back-pressure. The CPU is stalled for the whole sequence and must take each strobe in its own cycle. The register port is a plain single-cycle write with a combinational read.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, all six registers read 0, and `int_pending`, `seq_busy`, `stk_we`, `sp_load`, `vec_valid` and `acc_done` are 0.
- R2: The registers map as follows:
  - Address 0 holds the enable flags for sources 7..4 in bits 7..4 and the master enable in bit 0.
  - Address 1 holds the flags for sources 15..8 in bits 7..0.
  - Address 2 holds the flags for sources 21..16 in bits 5..0.
  - Addresses 3, 4 and 5 hold the latches at the same bit positions. Address 3 bit 2 reads the non-maskable latch.
  - Unused bits read 0. Writes take effect at the next clock edge.
- R3: A request input held high in a cycle sets its latch at the next edge. The latch holds until the source is accepted or software writes a 0 to its bit. Writing a 1 to a latch bit has no effect. A request arriving in the same cycle as a software clear leaves the latch set.
- R4: `int_pending` is 1 for a maskable latch only when both that source's enable flag and the master enable are 1. An `insn_end` pulse with no pending request starts nothing.
- R5: Among eligible requests, the lowest source number is accepted. A set non-maskable latch (source 2) is accepted over any maskable request, even with the master enable at 0. `acc_src` shows the accepted source number throughout the sequence.
- R6: The sequence starts at the edge where `insn_end` is 1, the block is idle and a request is pending. `seq_busy` is then high for exactly 8 cycles, numbered 0..7, and `acc_done` is high in cycle 7.
- R7: The master enable reads 0 from cycle 0 of the sequence. The accepted source's latch reads 0 from cycle 1.
- R8: The sequence writes the stack as follows:
  - Cycle 1 writes the status byte to address SP. Bits 7..1 of that byte are `status_rest`, and bit 0 is the master enable as it was before acceptance.
  - Cycle 2 writes PC[15:8] to SP-1.
  - Cycle 3 writes PC[7:0] to SP-2.
  - SP and PC are the values of `sp_cur` and `pc_cur` at the start edge.
- R9: In cycle 4, `sp_load` is 1 and `sp_next` equals SP-3.
- R10: In cycle 5, `vec_valid` is 1 and `vec_addr` equals 0xFFFE minus 2×n for accepted source n.
- R11: A pulse on `ret_mask` or `ret_nmi` sets the master enable to `ret_saved_me` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 18 | Maskable requests; bit i is source i+4 |
| nmi_req | input | 1 | Non-maskable request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| insn_end | input | 1 | Instruction boundary reached |
| pc_cur | input | 16 | Current program counter |
| sp_cur | input | 16 | Current stack pointer |
| status_rest | input | 7 | Status bits 7..1 to push |
| ret_mask | input | 1 | Maskable return executed |
| ret_nmi | input | 1 | Non-maskable return executed |
| ret_saved_me | input | 1 | Master enable bit from the popped status |
| int_pending | output | 1 | An eligible request is waiting |
| seq_busy | output | 1 | Acceptance sequence running |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_data | output | 8 | Stack write data |
| sp_load | output | 1 | Load new stack pointer |
| sp_next | output | 16 | New stack pointer |
| vec_valid | output | 1 | Vector fetch address valid |
| vec_addr | output | 16 | Vector fetch address |
| acc_src | output | 5 | Accepted source number |
| acc_done | output | 1 | Last cycle of the sequence |

## Verification
A latch that fails to clear on acceptance shows within one instruction boundary as a second acceptance of the same source. A latch that fails to set shows as `int_pending` staying low in the cycle after the request. A mis-stepped sequence counter moves a stack write, the stack pointer load or the vector strobe by one cycle, or swaps its address. The cycle-by-cycle checks of each sequence catch that within eight cycles. A wrong master enable shows at once in the register 0 read-back, and in bit 0 of the pushed status byte.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
  localparam int ID_W = 5;
  localparam int REG_BYTES = 3;
  localparam int FULL_W = 8 * REG_BYTES;
  localparam logic [2:0] A_EN0  = 3'd0;
  localparam logic [2:0] A_EN1  = 3'd1;
  localparam logic [2:0] A_EN2  = 3'd2;
  localparam logic [2:0] A_LAT0 = 3'd3;
  localparam logic [2:0] A_LAT1 = 3'd4;
  localparam logic [2:0] A_LAT2 = 3'd5;

  typedef enum logic [2:0] {
    ST_CLR  = 3'd0,
    ST_PSW  = 3'd1,
    ST_PCH  = 3'd2,
    ST_PCL  = 3'd3,
    ST_SP   = 3'd4,
    ST_VEC  = 3'd5,
    ST_W0   = 3'd6,
    ST_LAST = 3'd7
  } seq_step_e;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int NUM_MASK = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MASK-1:0] req,
  input  logic                nmi_req,
  input  logic [NUM_MASK-1:0] sw_clr,
  input  logic [NUM_MASK-1:0] acc_clr,
  input  logic                nmi_acc_clr,
  output logic [NUM_MASK-1:0] lat,
  output logic                nmi_lat
);
  // A new request always wins over any clear in the same cycle.
  for (genvar i = 0; i < NUM_MASK; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n) lat[i] <= 1'b0;
      else if (req[i]) lat[i] <= 1'b1;
      else if (sw_clr[i] || acc_clr[i]) lat[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nmi_lat <= 1'b0;
    else if (nmi_req) nmi_lat <= 1'b1;
    else if (nmi_acc_clr) nmi_lat <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_acc_pkg::*;
#(
  parameter int NUM_MASK = 18,
  parameter int FIRST    = 4,
  parameter int NMI_ID   = 2
) (
  input  logic [NUM_MASK-1:0] lat,
  input  logic [NUM_MASK-1:0] en,
  input  logic                master,
  input  logic                nmi_lat,
  output logic                any,
  output logic [ID_W-1:0]     win_id
);
  logic [NUM_MASK-1:0] elig;
  assign elig = lat & en & {NUM_MASK{master}};

  always_comb begin
    win_id = '0;
    for (int i = NUM_MASK - 1; i >= 0; i--) begin
      if (elig[i]) win_id = ID_W'(FIRST + i);
    end
    if (nmi_lat) win_id = ID_W'(NMI_ID);
    any = nmi_lat || (|elig);
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_acc_pkg::*;
#(
  parameter int NUM_MASK = 18,
  parameter int FIRST    = 4,
  parameter int NMI_ID   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [2:0]          addr,
  input  logic [7:0]          wdata,
  input  logic [NUM_MASK-1:0] lat,
  input  logic                nmi_lat,
  input  logic                seq_start,
  input  logic                ret_any,
  input  logic                ret_me,
  output logic [NUM_MASK-1:0] en,
  output logic                master,
  output logic [NUM_MASK-1:0] lat_wclr,
  output logic [7:0]          rdata
);
  // FIRST + NUM_MASK must not exceed FULL_W.
  logic [FULL_W-1:0] en_full;
  logic [FULL_W-1:0] lat_full;

  for (genvar i = 0; i < NUM_MASK; i++) begin : g_flag
    localparam int POS = FIRST + i;
    localparam int BITP = POS % 8;
    localparam logic [2:0] EA = 3'(POS / 8);
    localparam logic [2:0] LA = 3'(3 + POS / 8);

    always_ff @(posedge clk) begin
      if (!rst_n) en[i] <= 1'b0;
      else if (we && addr == EA) en[i] <= wdata[BITP];
    end

    assign lat_wclr[i] = we && (addr == LA) && !wdata[BITP];
  end

  // Start of acceptance beats a return, and a return beats a software write.
  always_ff @(posedge clk) begin
    if (!rst_n) master <= 1'b0;
    else if (seq_start) master <= 1'b0;
    else if (ret_any) master <= ret_me;
    else if (we && addr == A_EN0) master <= wdata[0];
  end

  always_comb begin
    en_full = '0;
    lat_full = '0;
    en_full[0] = master;
    lat_full[NMI_ID] = nmi_lat;
    for (int i = 0; i < NUM_MASK; i++) begin
      en_full[FIRST + i] = en[i];
      lat_full[FIRST + i] = lat[i];
    end
  end

  always_comb begin
    case (addr)
      A_EN0:  rdata = en_full[7:0];
      A_EN1:  rdata = en_full[15:8];
      A_EN2:  rdata = en_full[23:16];
      A_LAT0: rdata = lat_full[7:0];
      A_LAT1: rdata = lat_full[15:8];
      A_LAT2: rdata = lat_full[23:16];
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_acc_pkg::*;
#(
  parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] win_id,
  input  logic [15:0]     pc_cur,
  input  logic [15:0]     sp_cur,
  input  logic [6:0]      status_rest,
  input  logic            master_now,
  output logic            busy,
  output logic            clr_pulse,
  output logic [ID_W-1:0] acc_src,
  output logic            stk_we,
  output logic [15:0]     stk_addr,
  output logic [7:0]      stk_data,
  output logic            sp_load,
  output logic [15:0]     sp_next,
  output logic            vec_valid,
  output logic [15:0]     vec_addr,
  output logic            acc_done
);
  seq_step_e  step_q;
  logic [15:0] pc_q, sp_q;
  logic [7:0]  psw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      step_q  <= ST_CLR;
      acc_src <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      psw_q   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      step_q  <= ST_CLR;
      acc_src <= win_id;
      pc_q    <= pc_cur;
      sp_q    <= sp_cur;
      psw_q   <= {status_rest, master_now};
    end else if (busy) begin
      if (step_q == ST_LAST) busy <= 1'b0;
      step_q <= seq_step_e'(step_q + 3'd1);
    end
  end

  always_comb begin
    stk_we    = 1'b0;
    stk_addr  = sp_q;
    stk_data  = psw_q;
    sp_load   = 1'b0;
    vec_valid = 1'b0;
    acc_done  = 1'b0;
    clr_pulse = 1'b0;
    if (busy) begin
      case (step_q)
        ST_CLR: clr_pulse = 1'b1;
        ST_PSW: begin
          stk_we   = 1'b1;
          stk_addr = sp_q;
          stk_data = psw_q;
        end
        ST_PCH: begin
          stk_we   = 1'b1;
          stk_addr = sp_q - 16'd1;
          stk_data = pc_q[15:8];
        end
        ST_PCL: begin
          stk_we   = 1'b1;
          stk_addr = sp_q - 16'd2;
          stk_data = pc_q[7:0];
        end
        ST_SP:   sp_load = 1'b1;
        ST_VEC:  vec_valid = 1'b1;
        ST_LAST: acc_done = 1'b1;
        default: ;
      endcase
    end
  end

  assign sp_next  = sp_q - 16'd3;
  assign vec_addr = VEC_BASE - (16'(acc_src) << 1);
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_acc_pkg::*;
#(
  parameter int          NUM_MASK = 18,
  parameter int          FIRST    = 4,
  parameter int          NMI_ID   = 2,
  parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MASK-1:0] src_req,
  input  logic                nmi_req,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                insn_end,
  input  logic [15:0]         pc_cur,
  input  logic [15:0]         sp_cur,
  input  logic [6:0]          status_rest,
  input  logic                ret_mask,
  input  logic                ret_nmi,
  input  logic                ret_saved_me,
  output logic                int_pending,
  output logic                seq_busy,
  output logic                stk_we,
  output logic [15:0]         stk_addr,
  output logic [7:0]          stk_data,
  output logic                sp_load,
  output logic [15:0]         sp_next,
  output logic                vec_valid,
  output logic [15:0]         vec_addr,
  output logic [ID_W-1:0]     acc_src,
  output logic                acc_done
);
  logic [NUM_MASK-1:0] lat, en, lat_wclr, acc_clr;
  logic                nmi_lat, master_q, any, start, clr_pulse, nmi_acc_clr;
  logic [ID_W-1:0]     win_id;

  assign start = insn_end && !seq_busy && any;
  assign int_pending = any;

  irq_regfile #(.NUM_MASK(NUM_MASK), .FIRST(FIRST), .NMI_ID(NMI_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .lat(lat), .nmi_lat(nmi_lat), .seq_start(start),
    .ret_any(ret_mask || ret_nmi), .ret_me(ret_saved_me),
    .en(en), .master(master_q), .lat_wclr(lat_wclr), .rdata(reg_rdata)
  );

  irq_latch_bank #(.NUM_MASK(NUM_MASK)) u_lat (
    .clk(clk), .rst_n(rst_n), .req(src_req), .nmi_req(nmi_req),
    .sw_clr(lat_wclr), .acc_clr(acc_clr), .nmi_acc_clr(nmi_acc_clr),
    .lat(lat), .nmi_lat(nmi_lat)
  );

  irq_prio_pick #(.NUM_MASK(NUM_MASK), .FIRST(FIRST), .NMI_ID(NMI_ID)) u_pick (
    .lat(lat), .en(en), .master(master_q), .nmi_lat(nmi_lat),
    .any(any), .win_id(win_id)
  );

  irq_accept_seq #(.VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .win_id(win_id),
    .pc_cur(pc_cur), .sp_cur(sp_cur), .status_rest(status_rest),
    .master_now(master_q), .busy(seq_busy), .clr_pulse(clr_pulse),
    .acc_src(acc_src), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_data(stk_data), .sp_load(sp_load), .sp_next(sp_next),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .acc_done(acc_done)
  );

  for (genvar i = 0; i < NUM_MASK; i++) begin : g_acc_clr
    assign acc_clr[i] = clr_pulse && (acc_src == ID_W'(FIRST + i));
  end
  assign nmi_acc_clr = clr_pulse && (acc_src == ID_W'(NMI_ID));
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        master_q,
  input logic        nmi_lat,
  input logic        int_pending,
  input logic        seq_busy,
  input logic        stk_we,
  input logic [15:0] stk_addr,
  input logic        sp_load,
  input logic [15:0] sp_next,
  input logic        vec_valid,
  input logic [15:0] vec_addr,
  input logic [4:0]  acc_src,
  input logic        acc_done,
  input logic        ret_any,
  input logic        ret_saved_me
);
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pending && !nmi_lat) |-> master_q);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> seq_busy);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !seq_busy);

  p_master_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !master_q);

  p_push_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - 16'd1));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_we, sp_load, vec_valid, acc_done}));

  p_sp_after_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> ($past(stk_we) && sp_next == $past(stk_addr) - 16'd1));

  p_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(sp_load) && vec_addr == VEC_BASE - {10'd0, acc_src, 1'b0}));

  p_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_any && !start) |=> (master_q == $past(ret_saved_me)));
endmodule

bind irq_accept_ctrl irq_accept_chk #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .master_q(master_q),
  .nmi_lat(nmi_lat), .int_pending(int_pending), .seq_busy(seq_busy),
  .stk_we(stk_we), .stk_addr(stk_addr), .sp_load(sp_load), .sp_next(sp_next),
  .vec_valid(vec_valid), .vec_addr(vec_addr), .acc_src(acc_src),
  .acc_done(acc_done), .ret_any(ret_mask || ret_nmi), .ret_saved_me(ret_saved_me)
);

// File: tb/irq_accept_ctrl_tb.sv
module irq_accept_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] src_req = '0;
  logic        nmi_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        insn_end = 1'b0;
  logic [15:0] pc_cur = '0;
  logic [15:0] sp_cur = '0;
  logic [6:0]  status_rest = '0;
  logic        ret_mask = 1'b0, ret_nmi = 1'b0, ret_saved_me = 1'b0;
  logic        int_pending, seq_busy, stk_we, sp_load, vec_valid, acc_done;
  logic [15:0] stk_addr, sp_next, vec_addr;
  logic [7:0]  stk_data;
  logic [4:0]  acc_src;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_accept_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .nmi_req(nmi_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .insn_end(insn_end), .pc_cur(pc_cur),
    .sp_cur(sp_cur), .status_rest(status_rest), .ret_mask(ret_mask),
    .ret_nmi(ret_nmi), .ret_saved_me(ret_saved_me), .int_pending(int_pending),
    .seq_busy(seq_busy), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_data(stk_data), .sp_load(sp_load), .sp_next(sp_next),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .acc_src(acc_src),
    .acc_done(acc_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_req(input logic [17:0] m, input logic nm);
    @(negedge clk);
    src_req = m; nmi_req = nm;
    @(negedge clk);
    src_req = '0; nmi_req = 1'b0;
  endtask

  function automatic logic [2:0] lat_addr(input int n);
    return 3'(3 + n / 8);
  endfunction

  // Run one acceptance and check every cycle of it against the requirements.
  task automatic run_seq(input int n, input logic me_before);
    logic [7:0] d;
    logic [15:0] sp, pc;
    logic [6:0] st;
    sp = 16'h0400 + 16'(n * 5);
    pc = 16'hA000 + 16'(n * 257);
    st = 7'(7'h2A ^ n);
    @(negedge clk);
    sp_cur = sp; pc_cur = pc; status_rest = st; insn_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_end = 1'b0; sp_cur = '0; pc_cur = '0; status_rest = '0;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      chk("R6 busy in sequence", seq_busy, 1'b1);
      case (k)
        0: begin
          rd(3'd0, d);
          chk("R7 master cleared", d[0], 1'b0);
          chk("R5 accepted source", acc_src, n[4:0]);
        end
        1: begin
          rd(lat_addr(n), d);
          chk("R7 latch cleared", d[n % 8], 1'b0);
          chk("R8 status write", {stk_we, stk_addr, stk_data}, {1'b1, sp, st, me_before});
        end
        2: chk("R8 pc high write", {stk_we, stk_addr, stk_data}, {1'b1, sp - 16'd1, pc[15:8]});
        3: chk("R8 pc low write", {stk_we, stk_addr, stk_data}, {1'b1, sp - 16'd2, pc[7:0]});
        4: chk("R9 sp load", {stk_we, sp_load, sp_next}, {1'b0, 1'b1, sp - 16'd3});
        5: chk("R10 vector", {vec_valid, vec_addr}, {1'b1, 16'hFFFE - 16'(2 * n)});
        6: chk("R6 idle step", {stk_we, sp_load, vec_valid, acc_done}, 4'b0000);
        7: chk("R6 done strobe", acc_done, 1'b1);
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R6 busy ends after 8", seq_busy, 1'b0);
  endtask

  task automatic enable_src(input int n, input logic me);
    if (n < 8) wr(3'd0, 8'(1 << n) | {7'd0, me});
    else begin
      wr(3'd0, {7'd0, me});
      wr(3'(n / 8), 8'(1 << (n % 8)));
    end
  endtask

  task automatic clear_all;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 register reset", d, 8'h00);
    end
    chk("R1 outputs idle", {int_pending, seq_busy, stk_we, sp_load, vec_valid, acc_done}, 6'd0);

    // R2 layout: write all ones, unused bits stay 0
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd0, d); chk("R2 reg0 mask", d, 8'hF1);
    rd(3'd1, d); chk("R2 reg1 mask", d, 8'hFF);
    rd(3'd2, d); chk("R2 reg2 mask", d, 8'h3F);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // Sweep every maskable source: gating then full acceptance
    for (int n = 4; n < 22; n++) begin
      pulse_req(18'(1 << (n - 4)), 1'b0);
      rd(lat_addr(n), d);
      chk("R3 latch set", d[n % 8], 1'b1);
      chk("R4 no pending when disabled", int_pending, 1'b0);
      wr(3'd0, 8'h01);
      chk("R4 master alone not enough", int_pending, 1'b0);
      enable_src(n, 1'b0);
      chk("R4 flag alone not enough", int_pending, 1'b0);
      @(negedge clk); insn_end = 1'b1;
      @(negedge clk); insn_end = 1'b0;
      chk("R4 no start when not pending", seq_busy, 1'b0);
      rd(lat_addr(n), d);
      chk("R3 latch held", d[n % 8], 1'b1);
      enable_src(n, 1'b1);
      chk("R4 pending when enabled", int_pending, 1'b1);
      run_seq(n, 1'b1);
      chk("R7 nothing pending after", int_pending, 1'b0);
      clear_all;
    end

    // R5 priority among two maskable requests plus source 21
    for (int n = 4; n < 21; n++) begin
      wr(3'd0, 8'hF1); wr(3'd1, 8'hFF); wr(3'd2, 8'h3F);
      pulse_req(18'(3 << (n - 4)) | 18'(1 << 17), 1'b0);
      run_seq(n, 1'b1);
      rd(lat_addr(n + 1), d);
      chk("R3 loser latch held", d[(n + 1) % 8], 1'b1);
      clear_all;
    end

    // R5 non-maskable beats maskable and ignores master
    wr(3'd1, 8'hFF);
    pulse_req(18'(1 << 6), 1'b1);
    rd(3'd3, d); chk("R2 nmi latch bit", d[2], 1'b1);
    chk("R5 nmi pending without master", int_pending, 1'b1);
    run_seq(2, 1'b0);
    rd(3'd3, d); chk("R7 nmi latch cleared", d[2], 1'b0);
    clear_all;

    // R3 software writes on latches
    pulse_req(18'(1 << 5), 1'b0);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); chk("R3 write 1 ignored", d[1], 1'b1);
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk("R3 write 0 clears", d[1], 1'b0);
    @(negedge clk);
    src_req = 18'(1 << 5); reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00;
    @(negedge clk);
    src_req = '0; reg_we = 1'b0;
    rd(3'd4, d); chk("R3 request beats clear", d[1], 1'b1);
    wr(3'd4, 8'h00);

    // R11 returns restore master
    @(negedge clk); ret_mask = 1'b1; ret_saved_me = 1'b1;
    @(negedge clk); ret_mask = 1'b0;
    rd(3'd0, d); chk("R11 maskable return sets", d[0], 1'b1);
    @(negedge clk); ret_nmi = 1'b1; ret_saved_me = 1'b0;
    @(negedge clk); ret_nmi = 1'b0;
    rd(3'd0, d); chk("R11 nmi return clears", d[0], 1'b0);
    @(negedge clk); ret_nmi = 1'b1; ret_saved_me = 1'b1;
    @(negedge clk); ret_nmi = 1'b0;
    rd(3'd0, d); chk("R11 nmi return sets", d[0], 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule